// File: doc/BRIEF.md
# Base Writeback Forwarding Interlock

This block sits at the issue stage of an in-order pipeline. It watches every instruction that issues and remembers the base register written back by a load or store that carries address writeback. The updated base is produced in the ALU pipeline. An ordinary consumer can read it only one cycle after the producer issues. The block compares the register numbers of each following instruction against that record. From the comparison it decides whether the instruction must wait one cycle. A load or store that uses the fresh value as its address base takes it instead through a short local path around the add stage.

The issue logic presents one instruction per cycle: a valid flag, a load/store class bit, a writeback flag, the base register number, and a set of general source operand numbers, each with its own enable. The block returns `stall`, which holds the instruction in issue for the current cycle. It also returns `fwd_base`, which steers the address adder's base operand onto the local path. A chain of back-to-back writeback loads on the same base therefore runs with no bubbles.

Top module: `bwb_interlock`

## Requirements
- R1: After reset no base update is pending, so an instruction reading any register issues with `stall`=0 and `fwd_base`=0.
- R2: An instruction that is not a load/store and that reads, through an enabled source operand, the base updated by a writeback load/store that issued in the previous cycle gets `stall`=1.
- R3: A load/store whose base field (`issue_base`, used only when `issue_is_ls`=1) equals the base updated by a writeback load/store in the previous cycle, and whose enabled sources do not name that register, issues with `stall`=0 and `fwd_base`=1.
- R4: A load/store that reads the freshly updated base through an enabled source operand (offset or store data), rather than as its base, gets `stall`=1 and `fwd_base`=0.
- R5: A stall lasts exactly one cycle. When the same instruction is presented again in the next cycle, it issues with `stall`=0.
- R6: A consumer separated from the producer by at least one other cycle, whether an idle cycle or an unrelated instruction, sees `stall`=0 and `fwd_base`=0.
- R7: A load/store without writeback, and any instruction that is not a load/store, creates no pending update.
- R8: Three consecutive writeback load/stores on the same base issue in three cycles. The second and third have `fwd_base`=1 and none of the three stalls.
- R9: A stalled writeback load/store records its base update only when it actually issues. A non-load/store reading that base in the cycle after the retry is therefore stalled.
- R10: A source operand whose enable bit is 0 is never compared, even when its register number matches the pending base.
- R11: When `issue_valid`=0, both `stall` and `fwd_base` are 0, and the idle cycle retires any pending update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented at issue |
| issue_is_ls | input | 1 | The instruction is a load or store |
| issue_wb | input | 1 | The load/store writes its updated address back to the base |
| issue_base | input | REG_W (4) | Base register number of a load/store |
| issue_src | input | NSRC*REG_W (8) | Source operand register numbers, operand k in bits [k*REG_W +: REG_W] |
| issue_src_en | input | NSRC (2) | Per-operand enable, bit k for operand k |
| stall | output | 1 | Hold the presented instruction this cycle |
| fwd_base | output | 1 | Take the address base from the local forwarding path |

## Verification
The producer is followed in the next cycle by several kinds of consumer, and each separates a different decision. A load/store using the value as its base must forward. The same class using it as an offset must stall. Any other instruction must stall. An instruction with the matching operand disabled must do neither. Inserting an idle cycle or an unrelated instruction between producer and consumer separates a one-cycle lifetime from a record that persists too long. A stall followed by a retry shows that the stall cannot repeat and that the retried instruction's own writeback is recorded only once it fires. A three-long chain on one base confirms bubble-free back-to-back forwarding.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

    localparam int DEF_NREGS = 16;
    localparam int DEF_NSRC  = 2;

    typedef enum logic [1:0] {
        HZ_NONE  = 2'd0,
        HZ_FWD   = 2'd1,
        HZ_STALL = 2'd2
    } hz_e;

    // Outcome of the hazard check for one presented instruction.
    function automatic hz_e hz_resolve(input logic valid,
                                       input logic hit_src,
                                       input logic hit_base);
        if (!valid)        return HZ_NONE;
        else if (hit_src)  return HZ_STALL;
        else if (hit_base) return HZ_FWD;
        else               return HZ_NONE;
    endfunction

endpackage

// File: rtl/bwb_track.sv
module bwb_track #(
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             is_ls,
    input  logic             wb,
    input  logic [REG_W-1:0] base,
    output logic             pend_v,
    output logic [REG_W-1:0] pend_r
);
    typedef struct packed {
        logic             v;
        logic [REG_W-1:0] r;
    } pend_t;

    pend_t cur_q, nxt;

    // A record lives for exactly one cycle; only an issued writeback
    // load/store creates one. A stalled cycle leaves fire low, so the
    // old record ages out and the held instruction is not yet recorded.
    always_comb begin
        nxt.v = fire && is_ls && wb;
        nxt.r = (fire && is_ls && wb) ? base : cur_q.r;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end

    assign pend_v = cur_q.v;
    assign pend_r = cur_q.r;
endmodule

// File: rtl/bwb_src_match.sv
module bwb_src_match #(
    parameter int REG_W = 4,
    parameter int NSRC  = 2
) (
    input  logic                  pend_v,
    input  logic [REG_W-1:0]      pend_r,
    input  logic [NSRC*REG_W-1:0] srcs,
    input  logic [NSRC-1:0]       src_en,
    output logic                  hit
);
    logic [NSRC-1:0] per_src;

    for (genvar k = 0; k < NSRC; k++) begin : g_cmp
        assign per_src[k] = src_en[k] && (srcs[k*REG_W +: REG_W] == pend_r);
    end

    assign hit = pend_v && (|per_src);
endmodule

// File: rtl/bwb_interlock.sv
module bwb_interlock
    import bwb_pkg::*;
#(
    parameter int NREGS = DEF_NREGS,
    parameter int NSRC  = DEF_NSRC,
    localparam int REG_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  issue_valid,
    input  logic                  issue_is_ls,
    input  logic                  issue_wb,
    input  logic [REG_W-1:0]      issue_base,
    input  logic [NSRC*REG_W-1:0] issue_src,
    input  logic [NSRC-1:0]       issue_src_en,
    output logic                  stall,
    output logic                  fwd_base
);
    logic             pend_v;
    logic [REG_W-1:0] pend_r;
    logic             hit_src;
    logic             hit_base;
    logic             fire;
    hz_e              verdict;

    bwb_src_match #(.REG_W(REG_W), .NSRC(NSRC)) u_match (
        .pend_v (pend_v),
        .pend_r (pend_r),
        .srcs   (issue_src),
        .src_en (issue_src_en),
        .hit    (hit_src)
    );

    assign hit_base = pend_v && issue_is_ls && (issue_base == pend_r);
    assign verdict  = hz_resolve(issue_valid, hit_src, hit_base);
    assign stall    = (verdict == HZ_STALL);
    assign fwd_base = (verdict == HZ_FWD);
    assign fire     = issue_valid && !stall;

    bwb_track #(.REG_W(REG_W)) u_track (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .is_ls  (issue_is_ls),
        .wb     (issue_wb),
        .base   (issue_base),
        .pend_v (pend_v),
        .pend_r (pend_r)
    );
endmodule

// File: rtl/bwb_interlock_chk.sv
module bwb_interlock_chk (
    input logic clk,
    input logic rst,
    input logic issue_valid,
    input logic issue_is_ls,
    input logic issue_wb,
    input logic stall,
    input logic fwd_base
);
    logic produced;
    assign produced = issue_valid && !stall && issue_is_ls && issue_wb;

    // R5: a stall never repeats in the following cycle
    p_single_stall_r5: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    // R6 / R7: with no writeback producer issued last cycle, nothing is flagged
    p_no_producer_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !produced |=> (!stall && !fwd_base));

    // R3: forwarding only serves a presented load/store
    p_fwd_only_ls_r3: assert property (@(posedge clk) disable iff (rst)
        fwd_base |-> (issue_valid && issue_is_ls));

    // R4: stall and forward are exclusive
    p_stall_fwd_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(stall && fwd_base));

    // R11: an idle issue slot raises neither output
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |-> (!stall && !fwd_base));
endmodule

bind bwb_interlock bwb_interlock_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_is_ls (issue_is_ls),
    .issue_wb    (issue_wb),
    .stall       (stall),
    .fwd_base    (fwd_base)
);

// File: tb/sim_bwb_interlock.sv
module sim_bwb_interlock;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       issue_valid = 1'b0;
    logic       issue_is_ls = 1'b0;
    logic       issue_wb = 1'b0;
    logic [3:0] issue_base = '0;
    logic [7:0] issue_src = '0;
    logic [1:0] issue_src_en = '0;
    logic       stall;
    logic       fwd_base;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bwb_interlock u0 (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_is_ls(issue_is_ls),
        .issue_wb(issue_wb), .issue_base(issue_base), .issue_src(issue_src),
        .issue_src_en(issue_src_en), .stall(stall), .fwd_base(fwd_base)
    );

    // Present one instruction for one cycle, then sample mid-cycle.
    task automatic step(input logic v, input logic ls, input logic wb,
                        input logic [3:0] base, input logic [3:0] s1,
                        input logic [3:0] s0, input logic [1:0] en);
        @(negedge clk);
        issue_valid = v; issue_is_ls = ls; issue_wb = wb;
        issue_base = base; issue_src = {s1, s0}; issue_src_en = en;
        #1;
    endtask

    task automatic expect_out(input string req, input logic es, input logic ef);
        checks++;
        if (stall !== es || fwd_base !== ef) begin
            errors++;
            $display("FAIL %s: stall=%b fwd_base=%b expected stall=%b fwd_base=%b",
                     req, stall, fwd_base, es, ef);
        end
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 2'b00);
    endtask

    task automatic t_reset();
        step(1'b1, 1'b1, 1'b0, 4'd0, 4'd0, 4'd0, 2'b11);
        expect_out("R1 first instruction after reset", 1'b0, 1'b0);
        idle();
    endtask

    task automatic t_nonls_consumer();
        step(1'b1, 1'b1, 1'b1, 4'd2, 4'd0, 4'd0, 2'b00);
        expect_out("R6 producer itself", 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 4'd0, 4'd2, 4'd7, 2'b10);
        expect_out("R2 alu reads updated base", 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 4'd0, 4'd2, 4'd7, 2'b10);
        expect_out("R5 retry after stall", 1'b0, 1'b0);
        idle();
        idle();
        expect_out("R11 idle slot", 1'b0, 1'b0);
    endtask

    task automatic t_ls_forward();
        step(1'b1, 1'b1, 1'b1, 4'd5, 4'd0, 4'd0, 2'b00);
        step(1'b1, 1'b1, 1'b0, 4'd5, 4'd0, 4'd0, 2'b00);
        expect_out("R3 load uses updated base", 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 4'd5, 2'b01);
        expect_out("R7 no record from load without wb", 1'b0, 1'b0);
        idle();
    endtask

    task automatic t_ls_offset();
        step(1'b1, 1'b1, 1'b1, 4'd3, 4'd0, 4'd0, 2'b00);
        step(1'b1, 1'b1, 1'b0, 4'd9, 4'd0, 4'd3, 2'b01);
        expect_out("R4 load uses updated reg as offset", 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0, 4'd9, 4'd0, 4'd3, 2'b01);
        expect_out("R5 retried load", 1'b0, 1'b0);
        idle();
    endtask

    task automatic t_gap();
        step(1'b1, 1'b1, 1'b1, 4'd4, 4'd0, 4'd0, 2'b00);
        idle();
        expect_out("R11 idle after producer", 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 4'd0, 4'd4, 4'd4, 2'b11);
        expect_out("R6 consumer after idle gap", 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1, 4'd4, 4'd0, 4'd0, 2'b00);
        step(1'b1, 1'b0, 1'b0, 4'd0, 4'd1, 4'd1, 2'b11);
        expect_out("R6 unrelated instruction between", 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 4'd4, 4'd0, 4'd4, 2'b01);
        expect_out("R6 consumer two cycles later", 1'b0, 1'b0);
        idle();
    endtask

    task automatic t_nonls_wb_flag();
        step(1'b1, 1'b0, 1'b1, 4'd6, 4'd0, 4'd0, 2'b00);
        step(1'b1, 1'b1, 1'b0, 4'd6, 4'd0, 4'd6, 2'b01);
        expect_out("R7 non-ls with wb flag records nothing", 1'b0, 1'b0);
        idle();
    endtask

    task automatic t_chain();
        step(1'b1, 1'b1, 1'b1, 4'd2, 4'd0, 4'd0, 2'b00);
        expect_out("R8 chain first", 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1, 4'd2, 4'd0, 4'd0, 2'b00);
        expect_out("R8 chain second", 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b1, 4'd2, 4'd0, 4'd0, 2'b00);
        expect_out("R8 chain third", 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 4'd2, 2'b01);
        expect_out("R2 alu after chain", 1'b1, 1'b0);
        idle();
    endtask

    task automatic t_stalled_producer();
        step(1'b1, 1'b1, 1'b1, 4'd2, 4'd0, 4'd0, 2'b00);
        step(1'b1, 1'b1, 1'b1, 4'd8, 4'd2, 4'd0, 2'b10);
        expect_out("R9 stalled wb load", 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1, 4'd8, 4'd2, 4'd0, 2'b10);
        expect_out("R9 retried wb load issues", 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 4'd0, 4'd8, 4'd0, 2'b10);
        expect_out("R9 consumer of retried update", 1'b1, 1'b0);
        idle();
    endtask

    task automatic t_disabled_src();
        step(1'b1, 1'b1, 1'b1, 4'd11, 4'd0, 4'd0, 2'b00);
        step(1'b1, 1'b0, 1'b0, 4'd11, 4'd11, 4'd11, 2'b00);
        expect_out("R10 disabled operands ignored", 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1, 4'd11, 4'd0, 4'd0, 2'b00);
        step(1'b1, 1'b0, 1'b0, 4'd0, 4'd11, 4'd0, 2'b01);
        expect_out("R10 only enabled operand compared", 1'b0, 1'b0);
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_nonls_consumer();
        t_ls_forward();
        t_ls_offset();
        t_gap();
        t_nonls_wb_flag();
        t_chain();
        t_stalled_producer();
        t_disabled_src();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule